// File: doc/BRIEF.md
# Cascaded Interrupt Priority Resolver

This block arbitrates sixteen interrupt request lines held in two 8-input controllers. The secondary controller is chained into input 2 of the primary one. Each controller keeps a request register and an in-service register. It takes a mask, a trigger-mode setting and a vector base from plain configuration inputs. From the current state the block shows, without a clock delay, whether an interrupt is pending and which 8-bit vector the processor would receive.

Request lines are set and cleared by single-cycle raise and lower pulses that carry an IRQ number. The processor side returns the vector it has taken through an acknowledge pulse. The block then maps that vector back to a line, marks the line in service and drops edge-mode requests. Because the secondary controller enters through primary input 2, its whole group ranks between primary lines 1 and 3.

Top module: `cascade_irq_resolver`

## Requirements
- R1: The pending output is high exactly when a candidate exists. The ranking from highest to lowest is primary 0, primary 1, secondary 8 to 15 (lower number first), then primary 3 to 7. Primary line 2 is never granted on its own. When nothing is pending, the vector output is 0.
- R2: A request is a candidate only when its own mask bit is 0. Secondary lines are candidates only while primary mask bit 2 is 0.
- R3: A raise of IRQ n in 0 to 7 sets primary request bit n. A raise of IRQ n in 8 to 15 sets secondary request bit n-8 and also primary request bit 2.
- R4: A raise or lower that carries IRQ number 2 acts on IRQ 9.
- R5: A lower of IRQ n in 0 to 7 clears primary request bit n. A lower of IRQ n in 8 to 15 clears secondary bit n-8. If afterwards no secondary request remains whose secondary mask bit is 0, primary request bit 2 is cleared too.
- R6: Raise and lower pulses with an IRQ number of 16 or more change nothing.
- R7: The vector of primary line n is primary base + n. The vector of secondary IRQ n is secondary base + (n-8), modulo 256.
- R8: An acknowledged vector v belongs to primary line v-base when primary base <= v <= primary base + 7. This range is checked first. Otherwise it belongs to secondary line v-base when v lies within the secondary range. A vector in neither range changes nothing.
- R9: An accepted acknowledge of a secondary line sets that line's secondary in-service bit and primary in-service bit 2. An accepted acknowledge of primary line n sets primary in-service bit n.
- R10: On an accepted acknowledge, a request bit whose trigger-mode bit is 0 (edge) is cleared, and one whose trigger-mode bit is 1 (level) stays set. For a secondary line, this rule applies to that line's secondary bit and also to primary bit 2, using primary trigger bit 2.
- R11: An acknowledge is accepted only when the addressed request bit is set and its own mask bit is 0. Otherwise no register changes.
- R12: At most one event is applied per cycle. Acknowledge wins over raise, and raise wins over lower. A pulse that loses is dropped.
- R13: A synchronous active-high reset clears all request and in-service bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_vld | input | 1 | Raise pulse |
| raise_irq | input | NUM_W | IRQ number for the raise |
| lower_vld | input | 1 | Lower pulse |
| lower_irq | input | NUM_W | IRQ number for the lower |
| ack_vld | input | 1 | Acknowledge pulse |
| ack_vec | input | VEC_W | Vector being acknowledged |
| pri_base | input | VEC_W | Primary vector base |
| sec_base | input | VEC_W | Secondary vector base |
| pri_mask | input | 8 | Primary mask, 1 = masked |
| sec_mask | input | 8 | Secondary mask, 1 = masked |
| pri_level | input | 8 | Primary trigger mode, 1 = level, 0 = edge |
| sec_level | input | 8 | Secondary trigger mode, 1 = level, 0 = edge |
| int_pending | output | 1 | An unmasked request is waiting |
| int_vector | output | VEC_W | Vector of the winning line, 0 when none |
| pri_req | output | 8 | Primary request register |
| sec_req | output | 8 | Secondary request register |
| pri_insvc | output | 8 | Primary in-service register |
| sec_insvc | output | 8 | Secondary in-service register |

## Verification
The acknowledge and the raise or lower pulses can arrive in the same cycle. Only the acknowledge may then touch the registers. The bench provokes this directly: it pairs a valid acknowledge with a raise of a fresh line, and it pairs an out-of-range acknowledge with a raise. It also lets the random stimulus assert two or three pulses together. A reference model that applies only the winning event judges the registers on the following cycle, and a raise that loses must leave no trace in the request bits.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

    localparam int LINES        = 8;
    localparam int LINE_W       = $clog2(LINES);
    localparam int CASCADE_PIN  = 2;
    localparam int REDIRECT_IRQ = 9;
    localparam int TOTAL_IRQS   = 2 * LINES;

    typedef logic [LINES-1:0]  line_vec_t;
    typedef logic [LINE_W-1:0] line_idx_t;

    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_ACK   = 2'd1,
        EV_RAISE = 2'd2,
        EV_LOWER = 2'd3
    } ev_kind_e;

    // Decoded event: which kind won this cycle and the line it names.
    typedef struct packed {
        ev_kind_e  kind;
        logic      known;
        logic      sec;
        line_idx_t line;
    } irq_event_t;

    // Reference to one line of either controller.
    typedef struct packed {
        logic      hit;
        logic      sec;
        line_idx_t line;
    } line_ref_t;

    function automatic line_vec_t line_bit(input line_idx_t idx);
        return line_vec_t'(1) << idx;
    endfunction

endpackage

// File: rtl/cirq_event_sel.sv
module cirq_event_sel
    import cirq_pkg::*;
#(
    parameter int NUM_W = 8
) (
    input  logic             raise_vld,
    input  logic [NUM_W-1:0] raise_irq,
    input  logic             lower_vld,
    input  logic [NUM_W-1:0] lower_irq,
    input  logic             ack_vld,
    output irq_event_t       ev
);

    logic [NUM_W-1:0] num;
    logic [NUM_W-1:0] eff;

    always_comb begin
        num     = '0;
        ev.kind = EV_IDLE;
        if (ack_vld) begin
            ev.kind = EV_ACK;
        end else if (raise_vld) begin
            ev.kind = EV_RAISE;
            num     = raise_irq;
        end else if (lower_vld) begin
            ev.kind = EV_LOWER;
            num     = lower_irq;
        end
        // line 2 of the primary is the cascade input; traffic for it is rerouted
        eff      = (num == NUM_W'(CASCADE_PIN)) ? NUM_W'(REDIRECT_IRQ) : num;
        ev.known = (eff < NUM_W'(TOTAL_IRQS));
        ev.sec   = eff[LINE_W];
        ev.line  = eff[LINE_W-1:0];
    end

endmodule

// File: rtl/cirq_bank.sv
module cirq_bank
    import cirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t set_req,
    input  line_vec_t clr_req,
    input  line_vec_t set_isr,
    output line_vec_t req,
    output line_vec_t isr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= '0;
            isr <= '0;
        end else begin
            req <= (req | set_req) & ~clr_req;
            isr <= isr | set_isr;
        end
    end

    // R13
    rst_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (req == '0 && isr == '0));

    // R12
    isr_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_isr));

    // R12
    set_clr_apart_chk: assert property (@(posedge clk) disable iff (rst)
        (set_req & clr_req) == '0);

endmodule

// File: rtl/cirq_arbiter.sv
module cirq_arbiter
    import cirq_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  line_vec_t        p_req,
    input  line_vec_t        p_mask,
    input  line_vec_t        s_req,
    input  line_vec_t        s_mask,
    input  logic [VEC_W-1:0] p_base,
    input  logic [VEC_W-1:0] s_base,
    output line_ref_t        grant,
    output logic             pending,
    output logic [VEC_W-1:0] vector
);

    line_vec_t p_cand;
    line_vec_t s_cand;

    always_comb begin
        p_cand = p_req & ~p_mask;
        s_cand = s_req & ~s_mask & {LINES{~p_mask[CASCADE_PIN]}};
        grant  = '0;
        // scan from lowest rank upward; later hits overwrite earlier ones
        for (int i = LINES - 1; i > CASCADE_PIN; i--) begin
            if (p_cand[i]) grant = '{hit: 1'b1, sec: 1'b0, line: line_idx_t'(i)};
        end
        for (int i = LINES - 1; i >= 0; i--) begin
            if (s_cand[i]) grant = '{hit: 1'b1, sec: 1'b1, line: line_idx_t'(i)};
        end
        for (int i = CASCADE_PIN - 1; i >= 0; i--) begin
            if (p_cand[i]) grant = '{hit: 1'b1, sec: 1'b0, line: line_idx_t'(i)};
        end
        pending = grant.hit;
        if (!grant.hit)
            vector = '0;
        else
            vector = (grant.sec ? s_base : p_base) + VEC_W'(grant.line);
    end

    // R2
    sec_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (grant.hit && grant.sec) |->
            (!p_mask[CASCADE_PIN] && s_req[grant.line] && !s_mask[grant.line]));

    // R1
    pri_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (grant.hit && !grant.sec) |->
            (p_req[grant.line] && !p_mask[grant.line] && grant.line != line_idx_t'(CASCADE_PIN)));

    // R1
    idle_vec_chk: assert property (@(posedge clk) disable iff (rst)
        !pending |-> (vector == '0));

endmodule

// File: rtl/cirq_ack_decode.sv
module cirq_ack_decode
    import cirq_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VEC_W-1:0] vec,
    input  logic [VEC_W-1:0] p_base,
    input  logic [VEC_W-1:0] s_base,
    output line_ref_t        target
);

    logic [VEC_W:0] p_diff;
    logic [VEC_W:0] s_diff;
    logic           p_in;
    logic           s_in;

    always_comb begin
        p_diff = {1'b0, vec} - {1'b0, p_base};
        s_diff = {1'b0, vec} - {1'b0, s_base};
        // in range when the difference is non-negative and below LINES
        p_in   = !p_diff[VEC_W] && (p_diff[VEC_W-1:LINE_W] == '0);
        s_in   = !s_diff[VEC_W] && (s_diff[VEC_W-1:LINE_W] == '0);
        target = '0;
        if (p_in)
            target = '{hit: 1'b1, sec: 1'b0, line: p_diff[LINE_W-1:0]};
        else if (s_in)
            target = '{hit: 1'b1, sec: 1'b1, line: s_diff[LINE_W-1:0]};
    end

    // R8
    ack_pri_map_chk: assert property (@(posedge clk) disable iff (rst)
        (target.hit && !target.sec) |-> (p_base + VEC_W'(target.line) == vec));

    // R8
    ack_sec_map_chk: assert property (@(posedge clk) disable iff (rst)
        (target.hit && target.sec) |-> (s_base + VEC_W'(target.line) == vec));

endmodule

// File: rtl/cascade_irq_resolver.sv
module cascade_irq_resolver
    import cirq_pkg::*;
#(
    parameter int NUM_W = 8,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raise_vld,
    input  logic [NUM_W-1:0] raise_irq,
    input  logic             lower_vld,
    input  logic [NUM_W-1:0] lower_irq,
    input  logic             ack_vld,
    input  logic [VEC_W-1:0] ack_vec,
    input  logic [VEC_W-1:0] pri_base,
    input  logic [VEC_W-1:0] sec_base,
    input  logic [7:0]       pri_mask,
    input  logic [7:0]       sec_mask,
    input  logic [7:0]       pri_level,
    input  logic [7:0]       sec_level,
    output logic             int_pending,
    output logic [VEC_W-1:0] int_vector,
    output logic [7:0]       pri_req,
    output logic [7:0]       sec_req,
    output logic [7:0]       pri_insvc,
    output logic [7:0]       sec_insvc
);

    irq_event_t ev;
    line_ref_t  tgt;
    line_ref_t  grant;
    line_vec_t  p_set, p_clr, p_isr_set;
    line_vec_t  s_set, s_clr, s_isr_set;
    line_vec_t  s_left;
    line_vec_t  casc_bit;

    cirq_event_sel #(.NUM_W(NUM_W)) u_evsel (
        .raise_vld (raise_vld),
        .raise_irq (raise_irq),
        .lower_vld (lower_vld),
        .lower_irq (lower_irq),
        .ack_vld   (ack_vld),
        .ev        (ev)
    );

    cirq_ack_decode #(.VEC_W(VEC_W)) u_ackdec (
        .clk    (clk),
        .rst    (rst),
        .vec    (ack_vec),
        .p_base (pri_base),
        .s_base (sec_base),
        .target (tgt)
    );

    always_comb begin
        casc_bit  = line_bit(line_idx_t'(CASCADE_PIN));
        p_set     = '0;
        p_clr     = '0;
        p_isr_set = '0;
        s_set     = '0;
        s_clr     = '0;
        s_isr_set = '0;
        s_left    = '0;
        unique case (ev.kind)
            EV_ACK: begin
                if (tgt.hit && !tgt.sec) begin
                    if (pri_req[tgt.line] && !pri_mask[tgt.line]) begin
                        p_isr_set = line_bit(tgt.line);
                        if (!pri_level[tgt.line]) p_clr = line_bit(tgt.line);
                    end
                end else if (tgt.hit && tgt.sec) begin
                    if (sec_req[tgt.line] && !sec_mask[tgt.line]) begin
                        s_isr_set = line_bit(tgt.line);
                        p_isr_set = casc_bit;
                        if (!sec_level[tgt.line]) s_clr = line_bit(tgt.line);
                        if (!pri_level[CASCADE_PIN]) p_clr = casc_bit;
                    end
                end
            end
            EV_RAISE: begin
                if (ev.known && !ev.sec) begin
                    p_set = line_bit(ev.line);
                end else if (ev.known) begin
                    s_set = line_bit(ev.line);
                    p_set = casc_bit;
                end
            end
            EV_LOWER: begin
                if (ev.known && !ev.sec) begin
                    p_clr = line_bit(ev.line);
                end else if (ev.known) begin
                    s_clr  = line_bit(ev.line);
                    s_left = sec_req & ~s_clr & ~sec_mask;
                    if (s_left == '0) p_clr = casc_bit;
                end
            end
            default: ;
        endcase
    end

    cirq_bank u_pri_bank (
        .clk     (clk),
        .rst     (rst),
        .set_req (p_set),
        .clr_req (p_clr),
        .set_isr (p_isr_set),
        .req     (pri_req),
        .isr     (pri_insvc)
    );

    cirq_bank u_sec_bank (
        .clk     (clk),
        .rst     (rst),
        .set_req (s_set),
        .clr_req (s_clr),
        .set_isr (s_isr_set),
        .req     (sec_req),
        .isr     (sec_insvc)
    );

    cirq_arbiter #(.VEC_W(VEC_W)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .p_req   (pri_req),
        .p_mask  (pri_mask),
        .s_req   (sec_req),
        .s_mask  (sec_mask),
        .p_base  (pri_base),
        .s_base  (sec_base),
        .grant   (grant),
        .pending (int_pending),
        .vector  (int_vector)
    );

    // R3
    raise_sec_chk: assert property (@(posedge clk) disable iff (rst)
        (raise_vld && !ack_vld && raise_irq >= NUM_W'(LINES) && raise_irq < NUM_W'(TOTAL_IRQS))
            |=> pri_req[CASCADE_PIN]);

    // R6
    far_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_vld && ((raise_vld && raise_irq >= NUM_W'(TOTAL_IRQS)) ||
                      (!raise_vld && lower_vld && lower_irq >= NUM_W'(TOTAL_IRQS))))
            |=> ($stable(pri_req) && $stable(sec_req)));

    // R12
    ack_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && !tgt.hit) |=>
            ($stable(pri_req) && $stable(sec_req) && $stable(pri_insvc) && $stable(sec_insvc)));

    // R9
    sec_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (s_isr_set != '0) |=> (pri_insvc[CASCADE_PIN] && ((sec_insvc & $past(s_isr_set)) != '0)));

    // R11
    dead_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && tgt.hit && !tgt.sec && (!pri_req[tgt.line] || pri_mask[tgt.line]))
            |=> ($stable(pri_req) && $stable(pri_insvc) && $stable(sec_req)));

    // R10
    level_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && tgt.hit && !tgt.sec && pri_req[tgt.line] && !pri_mask[tgt.line] && pri_level[tgt.line])
            |=> (pri_req[$past(tgt.line)]));

endmodule

// File: tb/cascade_irq_resolver_tb_top.sv
`timescale 1ns/1ps
module cascade_irq_resolver_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       raise_vld = 1'b0, lower_vld = 1'b0, ack_vld = 1'b0;
    logic [7:0] raise_irq = '0, lower_irq = '0, ack_vec = '0;
    logic [7:0] pri_base = '0, sec_base = '0;
    logic [7:0] pri_mask = '0, sec_mask = '0, pri_level = '0, sec_level = '0;
    logic       int_pending;
    logic [7:0] int_vector, pri_req, sec_req, pri_insvc, sec_insvc;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [7:0] m_preq = '0, m_sreq = '0, m_pisr = '0, m_sisr = '0;

    always #2.5 clk = ~clk;

    cascade_irq_resolver dut_i (
        .clk(clk), .rst(rst),
        .raise_vld(raise_vld), .raise_irq(raise_irq),
        .lower_vld(lower_vld), .lower_irq(lower_irq),
        .ack_vld(ack_vld), .ack_vec(ack_vec),
        .pri_base(pri_base), .sec_base(sec_base),
        .pri_mask(pri_mask), .sec_mask(sec_mask),
        .pri_level(pri_level), .sec_level(sec_level),
        .int_pending(int_pending), .int_vector(int_vector),
        .pri_req(pri_req), .sec_req(sec_req),
        .pri_insvc(pri_insvc), .sec_insvc(sec_insvc)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // rank k -> IRQ number: 0,1,8..15,3..7
    function automatic int rank_irq(int k);
        if (k < 2) return k;
        if (k < 10) return k + 6;
        return k - 7;
    endfunction

    // returns {pending, vector} from the model state and present config
    function automatic logic [8:0] exp_out();
        for (int k = 0; k < 15; k++) begin
            int q = rank_irq(k);
            if (q < 8) begin
                if (m_preq[q] && !pri_mask[q]) return {1'b1, 8'(pri_base + 8'(q))};
            end else begin
                if (!pri_mask[2] && m_sreq[q-8] && !sec_mask[q-8])
                    return {1'b1, 8'(sec_base + 8'(q-8))};
            end
        end
        return 9'd0;
    endfunction

    task automatic model_apply(bit rv, int rn, bit lv, int ln, bit av, int avec);
        int n;
        if (av) begin
            int pb = pri_base, sb = sec_base, v = avec & 255;
            if (v >= pb && v <= pb + 7) begin
                int l = v - pb;
                if (m_preq[l] && !pri_mask[l]) begin
                    m_pisr[l] = 1'b1;
                    if (!pri_level[l]) m_preq[l] = 1'b0;
                end
            end else if (v >= sb && v <= sb + 7) begin
                int l = v - sb;
                if (m_sreq[l] && !sec_mask[l]) begin
                    m_sisr[l] = 1'b1;
                    m_pisr[2] = 1'b1;
                    if (!sec_level[l]) m_sreq[l] = 1'b0;
                    if (!pri_level[2]) m_preq[2] = 1'b0;
                end
            end
        end else if (rv) begin
            n = (rn == 2) ? 9 : rn;
            if (n < 8) m_preq[n] = 1'b1;
            else if (n < 16) begin m_sreq[n-8] = 1'b1; m_preq[2] = 1'b1; end
        end else if (lv) begin
            n = (ln == 2) ? 9 : ln;
            if (n < 8) m_preq[n] = 1'b0;
            else if (n < 16) begin
                m_sreq[n-8] = 1'b0;
                if ((m_sreq & ~sec_mask) == 8'h00) m_preq[2] = 1'b0;
            end
        end
    endtask

    task automatic compare(string tag);
        logic [8:0] e = exp_out();
        chk(tag, "pending", int'(int_pending), int'(e[8]));
        chk(tag, "vector", int'(int_vector), int'(e[7:0]));
        chk(tag, "pri_req", int'(pri_req), int'(m_preq));
        chk(tag, "sec_req", int'(sec_req), int'(m_sreq));
        chk(tag, "pri_insvc", int'(pri_insvc), int'(m_pisr));
        chk(tag, "sec_insvc", int'(sec_insvc), int'(m_sisr));
    endtask

    // called at a negedge; applies one cycle of pulses, compares at the next negedge
    task automatic step(string tag, bit rv, int rn, bit lv, int ln, bit av, int avec);
        raise_vld = rv; raise_irq = 8'(rn);
        lower_vld = lv; lower_irq = 8'(ln);
        ack_vld   = av; ack_vec   = 8'(avec);
        model_apply(rv, rn, lv, ln, av, avec);
        @(posedge clk);
        @(negedge clk);
        raise_vld = 1'b0; lower_vld = 1'b0; ack_vld = 1'b0;
        compare(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare("R13");

        pri_base = 8'h20; sec_base = 8'h70;
        step("R3", 1, 5, 0, 0, 0, 0);          // pri 5 -> 0x25
        step("R3", 1, 12, 0, 0, 0, 0);         // sec 12 beats pri 5 -> 0x74
        step("R1", 1, 1, 0, 0, 0, 0);          // pri 1 on top -> 0x21
        step("R7", 0, 0, 0, 0, 0, 0);
        pri_mask = 8'h04;
        step("R2", 0, 0, 1, 1, 0, 0);          // secondary gated off -> 0x25
        pri_mask = 8'h00;
        step("R2", 0, 0, 0, 0, 0, 0);
        step("R4", 1, 2, 0, 0, 0, 0);          // lands on IRQ 9
        step("R6", 1, 20, 0, 0, 0, 0);
        step("R6", 0, 0, 1, 17, 0, 0);
        step("R6", 1, 200, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 1, 8'h74);      // edge ack of IRQ 12
        step("R10", 0, 0, 0, 0, 1, 8'h71);     // edge ack of IRQ 9
        pri_level = 8'h20;
        step("R10", 0, 0, 0, 0, 1, 8'h25);     // level: request stays
        step("R11", 0, 0, 0, 0, 1, 8'h23);     // not requested
        pri_mask = 8'h20;
        step("R11", 0, 0, 0, 0, 1, 8'h25);     // masked
        pri_mask = 8'h00;
        step("R8", 1, 6, 0, 0, 1, 8'h99);      // out of both ranges, raise dropped
        step("R12", 1, 7, 1, 5, 1, 8'h25);     // ack wins
        step("R12", 1, 3, 1, 5, 0, 0);         // raise wins over lower
        step("R4", 1, 11, 0, 0, 0, 0);
        sec_mask = 8'h08;
        step("R5", 1, 10, 0, 0, 0, 0);
        step("R5", 0, 0, 1, 10, 0, 0);         // only masked 11 left -> pri bit 2 drops
        sec_mask = 8'h00;
        step("R5", 1, 13, 0, 0, 0, 0);
        step("R5", 0, 0, 1, 11, 0, 0);         // 13 left -> pri bit 2 stays
        step("R4", 0, 0, 1, 2, 0, 0);

        for (int it = 0; it < 3000; it++) begin
            bit rv, lv, av;
            int rn, ln, avec;
            if (it % 40 == 0) begin
                rst = (it % 400 == 0);
                pri_base  = ($urandom_range(0, 4) == 0) ? 8'($urandom) : 8'(8 * $urandom_range(0, 31));
                sec_base  = ($urandom_range(0, 4) == 0) ? 8'($urandom) : 8'(8 * $urandom_range(0, 31));
                pri_mask  = 8'($urandom & $urandom & $urandom);
                sec_mask  = 8'($urandom & $urandom);
                pri_level = 8'($urandom);
                sec_level = 8'($urandom);
                if (rst) begin
                    @(posedge clk); @(negedge clk);
                    rst = 1'b0;
                    m_preq = '0; m_sreq = '0; m_pisr = '0; m_sisr = '0;
                    compare("R13");
                end
            end
            rv = ($urandom_range(0, 9) < 4);
            lv = ($urandom_range(0, 9) < 3);
            av = ($urandom_range(0, 9) < 3);
            rn = ($urandom_range(0, 19) == 0) ? int'($urandom_range(16, 255)) : int'($urandom_range(0, 15));
            ln = ($urandom_range(0, 19) == 0) ? int'($urandom_range(16, 255)) : int'($urandom_range(0, 15));
            begin
                logic [8:0] e = exp_out();
                avec = ($urandom_range(0, 3) != 0 && e[8]) ? int'(e[7:0]) : int'($urandom_range(0, 255));
            end
            step("R12", rv, rn, lv, ln, av, avec);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule